// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It reads a two-level table of page entries that sits in memory. A request carries three things: the virtual address, a read or write flag, and the frame number of the root table. That frame number comes from the requesting process's base register.

The walker makes two sequential word reads over a simple request/acknowledge memory port. The first read fetches the root entry and the second fetches the leaf entry. After each read it checks the entry's present bit. On the leaf it also checks the write-permission bit. When the access changes the leaf's used or modified flag, the walker writes the updated leaf back before it responds. Each walk ends in one of two ways: a physical address, or a fault with a two-bit cause.

Only one walk runs at a time. While `busy_o` is high, new requests are ignored.

Top module: `pt_walker`

## Requirements
- R1: The first read targets byte address {root_frame_i, vaddr_i[31:22], 2'b00}.
- R2: The second read targets {root_entry[31:12], vaddr_i[21:12], 2'b00}. Both levels use the same entry layout: bits 31:12 hold the frame, bit 0 is present, bit 1 is writable, bit 2 is used and bit 3 is modified.
- R3: A successful walk returns rsp_paddr_o = {leaf[31:12], vaddr_i[11:0]} with rsp_fault_o low and rsp_cause_o = 0.
- R4: A root entry with bit 0 clear ends the walk with cause 1 after exactly one memory access.
- R5: A leaf entry with bit 0 clear ends the walk with cause 2, and nothing is written.
- R6: A write access to a leaf whose bit 1 is clear ends the walk with cause 3, and nothing is written. A read access to such a page succeeds.
- R7: A successful access writes the leaf back to its own address with bit 2 set. A write access also sets bit 3. All other bits are unchanged.
- R8: The write-back is skipped when the required bits are already set, so the walk makes two accesses only.
- R9: The response is raised only after the write-back is acknowledged. It holds steady until rsp_ready_i. A fault response carries rsp_paddr_o = 0.
- R10: busy_o is high from acceptance until the response handshake completes, and requests presented while it is high are ignored. A memory request holds its address, data and direction steady until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, taken when busy_o is low |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_root_frame_i | input | 20 | Frame number of the root table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Updated leaf entry |
| mem_ack_i | input | 1 | Access complete, read data valid |
| mem_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 1 | Page fault |
| rsp_cause_o | output | 2 | 0 none, 1 root absent, 2 leaf absent, 3 write refused |

## Verification
Embedded assertions check the following on every cycle:
- memory and response signals stay stable under stall;
- a fault response carries a zero address;
- any write-back carries the present and used bits, plus the modified bit on writes;
- a missing root entry goes straight to a cause-1 response.

Other behaviours can only be shown by the bench's walks, because they depend on the contents of the table:
- the addresses the two reads select;
- the physical address formed;
- whether a write-back happens or is skipped;
- which cause a refused walk reports;
- that requests made while busy are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int unsigned IDX_W   = 10;
  parameter int unsigned OFF_W   = 12;
  parameter int unsigned VA_W    = 2 * IDX_W + OFF_W;
  parameter int unsigned FRAME_W = VA_W - OFF_W;
  parameter int unsigned PTE_W   = VA_W;
  parameter int unsigned ENT_B_W = $clog2(PTE_W / 8);
  parameter int unsigned ADDR_W  = FRAME_W + IDX_W + ENT_B_W;

  parameter int unsigned P_BIT = 0;
  parameter int unsigned W_BIT = 1;
  parameter int unsigned U_BIT = 2;
  parameter int unsigned M_BIT = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE       = 2'd0,
    CAUSE_ROOT_ABSENT = 2'd1,
    CAUSE_LEAF_ABSENT = 2'd2,
    CAUSE_WRITE_PROT  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ROOT, ST_RD_LEAF, ST_WB, ST_RSP
  } state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic               leaf_sel_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic [FRAME_W-1:0] l2_frame_i,
  input  logic [VA_W-1:0]    vaddr_i,
  output logic [ADDR_W-1:0]  ent_addr_o
);
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] base;

  always_comb begin
    idx  = leaf_sel_i ? vaddr_i[OFF_W +: IDX_W] : vaddr_i[OFF_W + IDX_W +: IDX_W];
    base = leaf_sel_i ? l2_frame_i : root_frame_i;
    ent_addr_o = {base, idx, {ENT_B_W{1'b0}}};
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             write_i,
  output logic             present_o,
  output logic             access_ok_o,
  output logic [PTE_W-1:0] upd_pte_o,
  output logic             need_wb_o
);
  always_comb begin
    present_o   = pte_i[P_BIT];
    access_ok_o = !write_i || pte_i[W_BIT];
    upd_pte_o   = pte_i;
    upd_pte_o[U_BIT] = 1'b1;
    if (write_i) upd_pte_o[M_BIT] = 1'b1;
    need_wb_o   = (upd_pte_o != pte_i);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [VA_W-1:0]     req_vaddr_i,
  input  logic                req_write_i,
  input  logic [FRAME_W-1:0]  req_root_frame_i,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [PTE_W-1:0]    mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [PTE_W-1:0]    mem_rdata_i,
  output logic                rsp_valid_o,
  input  logic                rsp_ready_i,
  output logic [VA_W-1:0]     rsp_paddr_o,
  output logic                rsp_fault_o,
  output logic [1:0]          rsp_cause_o
);
  state_e             state_q;
  logic [VA_W-1:0]    vaddr_q;
  logic               write_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] l2_frame_q;
  logic [PTE_W-1:0]   leaf_q;
  logic [VA_W-1:0]    paddr_q;
  cause_e             cause_q;

  logic             present, access_ok, need_wb;
  logic [PTE_W-1:0] upd_pte;

  ptw_addr_gen u_addr (
    .leaf_sel_i   (state_q != ST_RD_ROOT),
    .root_frame_i (root_q),
    .l2_frame_i   (l2_frame_q),
    .vaddr_i      (vaddr_q),
    .ent_addr_o   (mem_addr_o)
  );

  ptw_pte_eval u_eval (
    .pte_i       (mem_rdata_i),
    .write_i     (write_q),
    .present_o   (present),
    .access_ok_o (access_ok),
    .upd_pte_o   (upd_pte),
    .need_wb_o   (need_wb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      vaddr_q    <= '0;
      write_q    <= 1'b0;
      root_q     <= '0;
      l2_frame_q <= '0;
      leaf_q     <= '0;
      paddr_q    <= '0;
      cause_q    <= CAUSE_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          write_q <= req_write_i;
          root_q  <= req_root_frame_i;
          paddr_q <= '0;
          cause_q <= CAUSE_NONE;
          state_q <= ST_RD_ROOT;
        end
        ST_RD_ROOT: if (mem_ack_i) begin
          if (!present) begin
            cause_q <= CAUSE_ROOT_ABSENT;
            state_q <= ST_RSP;
          end else begin
            l2_frame_q <= mem_rdata_i[PTE_W-1:OFF_W];
            state_q    <= ST_RD_LEAF;
          end
        end
        ST_RD_LEAF: if (mem_ack_i) begin
          leaf_q <= upd_pte;
          if (!present) begin
            cause_q <= CAUSE_LEAF_ABSENT;
            state_q <= ST_RSP;
          end else if (!access_ok) begin
            cause_q <= CAUSE_WRITE_PROT;
            state_q <= ST_RSP;
          end else begin
            paddr_q <= {mem_rdata_i[PTE_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
            state_q <= need_wb ? ST_WB : ST_RSP;
          end
        end
        ST_WB:  if (mem_ack_i) state_q <= ST_RSP;
        ST_RSP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_RD_ROOT) || (state_q == ST_RD_LEAF) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_wdata_o = leaf_q;
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = (cause_q != CAUSE_NONE);
  assign rsp_cause_o = cause_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R10
  accept_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_cause_o));
  // R9
  fault_paddr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0);
  // R7
  wb_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[P_BIT] && mem_wdata_o[U_BIT] && (!write_q || mem_wdata_o[M_BIT]));
  // R4
  root_absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ROOT) && mem_ack_i && !mem_rdata_i[P_BIT] |=> rsp_valid_o && rsp_cause_o == 2'd1);
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [19:0] req_root = '0;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .req_root_frame_i(req_root), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause)
  );

  logic [31:0] tmem [logic [31:0]];
  logic [31:0] log_addr [8];
  logic        log_we [8];
  logic [31:0] log_wdata [8];
  int          log_n = 0;
  int          wait_cnt = 0;

  // memory model: ack after 0..2 idle cycles, one cycle wide
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = tmem.exists(mem_addr) ? tmem[mem_addr] : 32'h0;
        if (log_n < 8) begin
          log_addr[log_n] = mem_addr;
          log_we[log_n]   = mem_we;
          log_wdata[log_n] = mem_wdata;
        end
        log_n++;
        if (mem_we) tmem[mem_addr] = mem_wdata;
        wait_cnt = $urandom % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [19:0] root, input logic [31:0] va, input bit wr,
                      input logic [31:0] pte1, input logic [31:0] pte2, input bit poke);
    logic [31:0] a1, a2, upd, exp_pa;
    logic [1:0]  exp_cause;
    int          exp_n, tmo, dly;
    a1 = {root, va[31:22], 2'b00};
    a2 = {pte1[31:12], va[21:12], 2'b00};
    tmem.delete();
    tmem[a1] = pte1;
    tmem[a2] = pte2;
    upd = pte2 | 32'h4 | (wr ? 32'h8 : 32'h0);
    exp_pa = 32'h0;
    if (!pte1[0]) begin exp_cause = 2'd1; exp_n = 1; end
    else if (!pte2[0]) begin exp_cause = 2'd2; exp_n = 2; end
    else if (wr && !pte2[1]) begin exp_cause = 2'd3; exp_n = 2; end
    else begin
      exp_cause = 2'd0;
      exp_pa = {pte2[31:12], va[11:0]};
      exp_n = (upd != pte2) ? 3 : 2;
    end

    @(negedge clk);
    log_n = 0;
    chk(!busy, "R10 idle before request", {31'b0, busy}, 32'h0);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R10: requests while busy must be ignored
      req_valid = 1'b1; req_vaddr = ~va; req_write = ~wr; req_root = ~root;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    tmo = 0;
    while (!rsp_valid && tmo < 200) begin @(negedge clk); tmo++; end
    chk(rsp_valid, "R9 response raised", {31'b0, rsp_valid}, 32'h1);
    dly = $urandom % 3;
    repeat (dly) @(negedge clk);
    chk(rsp_valid, "R9 response held", {31'b0, rsp_valid}, 32'h1);
    chk(log_n == exp_n, "R4/R5/R8 access count at response", log_n, exp_n);
    chk(rsp_cause == exp_cause, "R4 R5 R6 cause", {30'b0, rsp_cause}, {30'b0, exp_cause});
    chk(rsp_fault == (exp_cause != 0), "R3 fault flag", {31'b0, rsp_fault}, {31'b0, exp_cause != 0});
    chk(rsp_paddr == exp_pa, "R3 R9 physical address", rsp_paddr, exp_pa);
    chk(log_n > 0 && log_addr[0] == a1 && !log_we[0], "R1 root entry read", log_addr[0], a1);
    if (exp_n >= 2)
      chk(log_addr[1] == a2 && !log_we[1], "R2 leaf entry read", log_addr[1], a2);
    if (exp_n == 3) begin
      chk(log_addr[2] == a2 && log_we[2], "R7 write-back address", log_addr[2], a2);
      chk(log_wdata[2] == upd, "R7 write-back data", log_wdata[2], upd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && log_n == exp_n, "R10 no extra walk", log_n, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p1, p2;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !rsp_valid, "R10 reset state", {29'b0, busy, mem_req, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    walk(20'h00010, 32'h1234_5678, 1'b0, 32'h0002_0001, 32'h0ABC_D003, 1'b0); // R7 read sets U
    walk(20'h00010, 32'hFFFF_FFFF, 1'b1, 32'h0002_0001, 32'h0ABC_D003, 1'b0); // R7 write sets U,M
    walk(20'h00030, 32'h0040_0ABC, 1'b0, 32'h0005_0001, 32'h1111_1007, 1'b0); // R8 U already set
    walk(20'h00030, 32'h0040_0ABC, 1'b1, 32'h0005_0001, 32'h2222_200F, 1'b0); // R8 U,M set
    walk(20'h00030, 32'h0040_0ABC, 1'b1, 32'h0005_0001, 32'h2222_2007, 1'b0); // R7 only M set
    walk(20'h00040, 32'h8000_0000, 1'b0, 32'h0006_0000, 32'h3333_3003, 1'b0); // R4
    walk(20'h00040, 32'h8000_0000, 1'b1, 32'h0006_0001, 32'h3333_300E, 1'b0); // R5
    walk(20'h00040, 32'h0000_1FFF, 1'b1, 32'h0006_0001, 32'h4444_4001, 1'b0); // R6 write refused
    walk(20'h00040, 32'h0000_1FFF, 1'b0, 32'h0006_0001, 32'h4444_4001, 1'b0); // R6 read allowed
    walk(20'h00050, 32'hABCD_E123, 1'b0, 32'h0007_0001, 32'h5555_5003, 1'b1); // R10 poke while busy
    walk(20'h00050, 32'hABCD_E123, 1'b0, 32'h0007_0000, 32'h5555_5003, 1'b1); // R10 poke in fault
    for (int i = 0; i < 60; i++) begin
      p1 = $urandom;
      p2 = $urandom;
      p1[0] = ($urandom % 8) != 0;
      p2[0] = ($urandom % 6) != 0;
      p1[31:12] = {4'h8, p1[27:12]};
      walk({4'h0, 16'($urandom)}, $urandom, 1'($urandom), p1, p2, (i % 5) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule